// File: doc/BRIEF.md
# Clock-Domain Quiesce and Reset Sequencer

This block runs in an always-on clock domain and takes a neighbouring register-crossing domain offline and back again in a safe order. It drives three control lines into that domain: a bypass line that makes master-side requests finish as no-ops instead of crossing, a domain reset, and a clock enable for an external gating cell. It watches a busy line from the crossing logic, which shows that a transfer is still in flight. The busy line is brought in through a synchronizer, and the drain only counts as complete after several low samples in a row.

Software or a power manager pulses `shut_req_i` to quiesce the domain and `wake_req_i` to bring it back. The sequencer accepts a request only while it rests in a stable state, which is either running or off. In the off state the domain is held in reset with its clock optionally stopped. The sequencer never signals that power may be removed. A parameter selects the variant: a slave-side domain, where bypass is raised first and dropped last, or a master-side domain, which has no bypass step.

Reset is held for a programmable number of cycles with the clock running. This happens before the clock is gated on the way down, and again after the clock is re-enabled on the way up.

Top module: `dom_quiesce_seq`

## Requirements
- R1: After power-on reset the outputs show the running state: `bypass_o`=0, `dom_rst_o`=0, `clk_en_o`=1, `off_o`=0, `idle_o`=1, `ready_o`=1.
- R2: In the slave-side variant, a shutdown request sampled at a clock edge while running sets `bypass_o` after that edge. `dom_rst_o` is still low at that point, and `idle_o` and `ready_o` drop.
- R3: `dom_rst_o` rises only once the synchronized busy line has read low on two consecutive edges. The synchronizer has two stages. If `busy_i` is first sampled low at edge j (after the request), reset rises after edge j+3. If busy has been low for a long time, reset rises two edges after the request edge. A single-cycle low pulse on busy does not complete the drain.
- R4: After reset rises, the sequencer holds `dom_rst_o`=1 with `clk_en_o`=1 for H cycles before it enters the off state. H is `hold_cycles_i`, and a value of 0 counts as 1.
- R5: In the off state `off_o`=1, `idle_o`=1 and `dom_rst_o`=1. `clk_en_o` equals the inverse of `gate_clk_i`. In the slave-side variant `bypass_o` stays 1.
- R6: A wake request sampled in the off state at edge w re-enables the clock with reset still high for H cycles. After edge w+H, reset is low while bypass (slave-side) is still high for one cycle. After edge w+H+1 the block is running with `bypass_o`=0 and `ready_o`=1.
- R7: In the master-side variant `bypass_o` is never asserted. All other outputs follow the same cycle timing as the slave-side variant.
- R8: Requests that arrive outside a stable state are ignored. This covers a wake request during drain, reset hold or release, and a shutdown request during the wake hold. A shutdown request while off and a wake request while running also have no effect.
- R9: `dom_rst_o` rises only while `clk_en_o`=1. It falls only after the clock has run for at least one cycle. The clock is disabled only while the domain is held in reset.
- R10: In the slave-side variant, bypass is high whenever reset rises. Bypass falls only after reset has been low for a full cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| shut_req_i | input | 1 | Request to quiesce and take the domain offline |
| wake_req_i | input | 1 | Request to bring the domain back |
| gate_clk_i | input | 1 | 1: stop the domain clock while off |
| hold_cycles_i | input | HOLD_W | Reset hold length in cycles (0 acts as 1) |
| busy_i | input | 1 | In-flight indication from the crossing logic, asynchronous |
| bypass_o | output | 1 | Make master requests complete as no-ops |
| dom_rst_o | output | 1 | Reset to the target domain |
| clk_en_o | output | 1 | Clock enable for the target domain gating cell |
| off_o | output | 1 | Domain is held off |
| idle_o | output | 1 | Sequencer is in a stable state and accepts a request |
| ready_o | output | 1 | Domain is running normally |

## Verification
The bench builds two instances side by side from the same stimulus. One is the slave-side variant and one is the master-side variant, both with `HOLD_W`=3. This lets every cycle-exact check compare bypass behaviour between the two variants. The hold length is swept over 0 to 4, so the zero-as-one rule and several window lengths are exercised. Each hold length is run with the clock gate both enabled and disabled. A separate pass holds busy high, applies a one-cycle low glitch, and then releases it, which exercises the exact synchronizer-plus-confirmation latency.

// File: rtl/dqs_pkg.sv
package dqs_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_DRAIN   = 3'd1,
      ST_HOLD_DN = 3'd2,
      ST_OFF     = 3'd3,
      ST_HOLD_UP = 3'd4,
      ST_REL     = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic bypass;
      logic rst;
      logic clk_en;
      logic off;
      logic idle;
      logic ready;
   } seq_out_t;

   localparam seq_out_t RUN_OUTS = '{bypass: 1'b0, rst: 1'b0, clk_en: 1'b1,
                                     off: 1'b0, idle: 1'b1, ready: 1'b1};

   // Output pattern for a state; bypass is returned for the slave-side view
   function automatic seq_out_t decode_outs(seq_state_e s, logic gate);
      seq_out_t o;
      o        = RUN_OUTS;
      o.idle   = (s == ST_RUN) || (s == ST_OFF);
      o.ready  = (s == ST_RUN);
      o.off    = (s == ST_OFF);
      o.bypass = (s != ST_RUN);
      o.rst    = (s == ST_HOLD_DN) || (s == ST_OFF) || (s == ST_HOLD_UP);
      o.clk_en = (s == ST_OFF) ? !gate : 1'b1;
      return o;
   endfunction

endpackage

// File: rtl/dqs_sync.sv
module dqs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("dqs_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[i] <= RST_VAL;
         end else begin
            chain[i] <= (i == 0) ? d_i : chain[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/dqs_drain_det.sv
module dqs_drain_det #(
   parameter int LOWS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic busy_s_i,
   output logic done_o
);

   localparam int CW = (LOWS < 2) ? 1 : $clog2(LOWS);
   localparam logic [CW-1:0] LAST = CW'(LOWS - 1);

   logic [CW-1:0] low_cnt;

   if (LOWS < 1) begin : g_bad_lows
      $error("dqs_drain_det: LOWS must be at least 1");
   end

   assign done_o = arm_i && !busy_s_i && (low_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (!arm_i || busy_s_i) begin
         low_cnt <= '0;
      end else if (low_cnt != LAST) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/dqs_hold_timer.sv
module dqs_hold_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm_i,
   input  logic [W-1:0] hold_i,
   output logic         done_o
);

   logic [W-1:0] cnt;
   logic [W-1:0] last;

   if (W < 1) begin : g_bad_w
      $error("dqs_hold_timer: W must be at least 1");
   end

   assign last   = (hold_i == '0) ? '0 : hold_i - 1'b1;
   assign done_o = arm_i && (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!arm_i) begin
         cnt <= '0;
      end else if (!done_o) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/dom_quiesce_seq.sv
module dom_quiesce_seq
   import dqs_pkg::*;
#(
   parameter bit SLAVE_SIDE  = 1'b1,
   parameter int HOLD_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DRAIN_LOWS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shut_req_i,
   input  logic              wake_req_i,
   input  logic              gate_clk_i,
   input  logic [HOLD_W-1:0] hold_cycles_i,
   input  logic              busy_i,
   output logic              bypass_o,
   output logic              dom_rst_o,
   output logic              clk_en_o,
   output logic              off_o,
   output logic              idle_o,
   output logic              ready_o
);

   seq_state_e state_q, state_d;
   seq_out_t   outs_d, outs_q;
   logic       busy_s;
   logic       drain_done;
   logic       hold_done;
   logic       in_hold;

   if (HOLD_W < 1) begin : g_bad_hold
      $error("dom_quiesce_seq: HOLD_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dom_quiesce_seq: SYNC_STAGES must be at least 2");
   end

   // Busy is assumed present out of reset, so a drain cannot finish early
   dqs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (busy_i),
      .q_o   (busy_s)
   );

   dqs_drain_det #(.LOWS(DRAIN_LOWS)) u_drain (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (state_q == ST_DRAIN),
      .busy_s_i (busy_s),
      .done_o   (drain_done)
   );

   assign in_hold = (state_q == ST_HOLD_DN) || (state_q == ST_HOLD_UP);

   dqs_hold_timer #(.W(HOLD_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (in_hold),
      .hold_i (hold_cycles_i),
      .done_o (hold_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:     if (shut_req_i) state_d = ST_DRAIN;
         ST_DRAIN:   if (drain_done) state_d = ST_HOLD_DN;
         ST_HOLD_DN: if (hold_done)  state_d = ST_OFF;
         ST_OFF:     if (wake_req_i) state_d = ST_HOLD_UP;
         ST_HOLD_UP: if (hold_done)  state_d = ST_REL;
         ST_REL:                     state_d = ST_RUN;
         default:                    state_d = ST_RUN;
      endcase
   end

   assign outs_d = decode_outs(state_d, gate_clk_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         outs_q  <= RUN_OUTS;
      end else begin
         state_q <= state_d;
         outs_q  <= outs_d;
      end
   end

   if (SLAVE_SIDE) begin : g_slave
      assign bypass_o = outs_q.bypass;
   end else begin : g_master
      assign bypass_o = 1'b0;
   end

   assign dom_rst_o = outs_q.rst;
   assign clk_en_o  = outs_q.clk_en;
   assign off_o     = outs_q.off;
   assign idle_o    = outs_q.idle;
   assign ready_o   = outs_q.ready;

endmodule

// File: rtl/dqs_checker.sv
module dqs_checker #(
   parameter bit SLAVE_SIDE  = 1'b1,
   parameter int HOLD_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DRAIN_LOWS  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shut_req_i,
   input logic              wake_req_i,
   input logic              gate_clk_i,
   input logic [HOLD_W-1:0] hold_cycles_i,
   input logic              busy_i,
   input logic              bypass_o,
   input logic              dom_rst_o,
   input logic              clk_en_o,
   input logic              off_o,
   input logic              idle_o,
   input logic              ready_o
);

   a_r9_rst_rise_clocked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst_o) |-> clk_en_o);

   a_r9_rst_fall_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_rst_o) |-> clk_en_o && $past(clk_en_o));

   a_r9_gate_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_o |-> dom_rst_o && off_o);

   a_r5_off_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      off_o |-> dom_rst_o && idle_o && !ready_o);

   a_r1_ready_clean: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !bypass_o && !dom_rst_o && clk_en_o);

   a_r8_leave_run_on_shut: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_o) |-> $past(shut_req_i));

   a_r8_leave_off_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(off_o) |-> $past(wake_req_i));

   if (SLAVE_SIDE) begin : g_slave_chk
      a_r10_bypass_before_rst: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dom_rst_o) |-> bypass_o && $past(bypass_o));
      a_r10_bypass_drop_last: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(bypass_o) |-> !dom_rst_o && !$past(dom_rst_o));
   end else begin : g_master_chk
      a_r7_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
         !bypass_o);
   end

   if (SYNC_STAGES == 2 && DRAIN_LOWS == 2) begin : g_drain_chk
      a_r3_drained_before_rst: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(dom_rst_o) |-> !$past(busy_i, 3) && !$past(busy_i, 4));
   end

endmodule

bind dom_quiesce_seq dqs_checker #(
   .SLAVE_SIDE  (SLAVE_SIDE),
   .HOLD_W      (HOLD_W),
   .SYNC_STAGES (SYNC_STAGES),
   .DRAIN_LOWS  (DRAIN_LOWS)
) u_chk (.*);

// File: tb/dom_quiesce_seq_tb.sv
module dom_quiesce_seq_tb;

   localparam int HW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shut = 1'b0, wake = 1'b0, gate = 1'b0, busy = 1'b0;
   logic [HW-1:0] hold = HW'(1);
   logic s_byp, s_rst, s_ce, s_off, s_idle, s_rdy;
   logic m_byp, m_rst, m_ce, m_off, m_idle, m_rdy;
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dom_quiesce_seq #(.SLAVE_SIDE(1'b1), .HOLD_W(HW)) u_dut (
      .clk(clk), .rst_n(rst_n), .shut_req_i(shut), .wake_req_i(wake),
      .gate_clk_i(gate), .hold_cycles_i(hold), .busy_i(busy),
      .bypass_o(s_byp), .dom_rst_o(s_rst), .clk_en_o(s_ce), .off_o(s_off),
      .idle_o(s_idle), .ready_o(s_rdy));

   dom_quiesce_seq #(.SLAVE_SIDE(1'b0), .HOLD_W(HW)) u_dut_m (
      .clk(clk), .rst_n(rst_n), .shut_req_i(shut), .wake_req_i(wake),
      .gate_clk_i(gate), .hold_cycles_i(hold), .busy_i(busy),
      .bypass_o(m_byp), .dom_rst_o(m_rst), .clk_en_o(m_ce), .off_o(m_off),
      .idle_o(m_idle), .ready_o(m_rdy));

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare both variants; the master variant must never show bypass
   task automatic chk_st(string req, logic byp, logic r, logic ce,
                         logic off, logic idle, logic rdy);
      chk(req, "s.bypass", s_byp, byp);
      chk(req, "s.rst", s_rst, r);
      chk(req, "s.clk_en", s_ce, ce);
      chk(req, "s.off", s_off, off);
      chk(req, "s.idle", s_idle, idle);
      chk(req, "s.ready", s_rdy, rdy);
      chk("R7", "m.bypass", m_byp, 1'b0);
      chk(req, "m.rst", m_rst, r);
      chk(req, "m.clk_en", m_ce, ce);
      chk(req, "m.off", m_off, off);
      chk(req, "m.idle", m_idle, idle);
      chk(req, "m.ready", m_rdy, rdy);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      int heff;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_st("R1", 0, 0, 1, 0, 1, 1);
      repeat (4) @(negedge clk);

      for (int g = 0; g < 2; g++) begin
         for (int h = 0; h < 5; h++) begin
            gate = g[0];
            hold = HW'(h);
            heff = (h == 0) ? 1 : h;
            // shutdown with busy long idle
            shut = 1'b1; @(negedge clk); shut = 1'b0;
            chk_st("R2", 1, 0, 1, 0, 0, 0);
            wake = 1'b1; @(negedge clk); wake = 1'b0;      // R8: wake during drain
            chk_st("R3", 1, 0, 1, 0, 0, 0);
            @(negedge clk);
            for (int i = 0; i < heff; i++) begin
               chk_st("R4", 1, 1, 1, 0, 0, 0);
               @(negedge clk);
            end
            chk_st("R5", 1, 1, !gate, 1, 1, 0);
            shut = 1'b1; @(negedge clk); shut = 1'b0;      // R8: shutdown while off
            chk_st("R8", 1, 1, !gate, 1, 1, 0);
            wake = 1'b1; @(negedge clk); wake = 1'b0;
            shut = 1'b1;                                   // R8: shutdown during wake
            for (int i = 0; i < heff; i++) begin
               chk_st("R6", 1, 1, 1, 0, 0, 0);
               @(negedge clk);
               shut = 1'b0;
            end
            chk_st("R6", 1, 0, 1, 0, 0, 0);
            @(negedge clk);
            chk_st("R6", 0, 0, 1, 0, 1, 1);
            repeat (3) @(negedge clk);
            chk_st("R8", 0, 0, 1, 0, 1, 1);
            wake = 1'b1; @(negedge clk); wake = 1'b0;      // R8: wake while running
            chk_st("R8", 0, 0, 1, 0, 1, 1);
            @(negedge clk);
         end
      end

      // busy drain latency with a glitch
      gate = 1'b1;
      hold = HW'(2);
      busy = 1'b1;
      repeat (3) @(negedge clk);
      shut = 1'b1; @(negedge clk); shut = 1'b0;
      for (int i = 0; i < 6; i++) begin
         chk_st("R3", 1, 0, 1, 0, 0, 0);
         @(negedge clk);
      end
      busy = 1'b0; @(negedge clk); busy = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk_st("R3", 1, 0, 1, 0, 0, 0);
      end
      busy = 1'b0;
      @(negedge clk); chk("R3", "rst j", s_rst, 1'b0);
      @(negedge clk); chk("R3", "rst j+1", s_rst, 1'b0);
      @(negedge clk); chk("R3", "rst j+2", s_rst, 1'b0);
      @(negedge clk); chk_st("R3", 1, 1, 1, 0, 0, 0);
      repeat (2) @(negedge clk);
      chk_st("R5", 1, 1, 0, 1, 1, 0);
      wake = 1'b1; @(negedge clk); wake = 1'b0;
      repeat (3) @(negedge clk);
      chk_st("R6", 0, 0, 1, 0, 1, 1);

      summary();
      $finish;
   end

endmodule